// File: doc/BRIEF.md
# Prescaled Interrupt Timer (8-bit, cycle or scanline pacing)

This block is an 8-bit up-counting interrupt timer paced by a CPU-cycle enable. In cycle pacing the counter advances once for every CPU cycle. In scanline pacing a signed prescaler approximates one advance per 341 video dots: it loses 3 on every CPU cycle and, when it reaches zero or goes below, gets 341 added back and advances the counter once. Over a long run this comes to 341 dots per advance, at 3 dots per CPU cycle.

Software reaches the timer through four write-only registers picked by a 2-bit select. Two of them set the reload value one nibble at a time. One holds the control bits. The fourth acknowledges an interrupt. When the counter passes 0xFF it takes the reload value again and raises the interrupt line. The line stays high until software writes the control or acknowledge register. A global run input, driven by the surrounding mapper-mode decode, freezes the whole timer when it is low.

Top module: `irqtmr_top`

## Requirements
- R1: A write with select 0 sets reload bits 3:0 from data bits 3:0. A write with select 1 sets reload bits 7:4 from data bits 3:0. Data bits 7:4 are ignored in both.
- R2: A write with select 2 stores control bits 2:0 (bit 0 enable-after-ack, bit 1 enable, bit 2 cycle pacing) and drops the interrupt line. If bit 1 is set, the counter is loaded from the reload value and the prescaler is set to 341.
- R3: A write with select 3 drops the interrupt line and copies control bit 0 into control bit 1. The counter and prescaler keep their values.
- R4: With enable and cycle pacing set, the counter advances once on every clock where cpu_tick is high.
- R5: With enable set and cycle pacing clear, each cpu_tick takes 3 from the prescaler. When the result is zero or below, 341 is added and the counter advances. Starting from 341, the advances come after 114, 114 and 113 ticks, and the pattern repeats.
- R6: An advance from 0xFF loads the reload value into the counter and sets the interrupt line in the same clock. The line then stays high until a select 2 or select 3 write.
- R7: While run_en is low, the counter and prescaler hold and no interrupt is raised.
- R8: Synchronous reset clears the reload value, the control bits, the counter, the prescaler and the interrupt line.
- R9: Clocks with cpu_tick low leave the counter and prescaler unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 reload low, 1 reload high, 2 control, 3 acknowledge |
| wr_data | input | 8 | Write data |
| cpu_tick | input | 1 | One-clock pulse per CPU cycle |
| run_en | input | 1 | Global run enable from the mapper mode decode |
| irq | output | 1 | Interrupt request, held until cleared by a write |

## Verification
The assertions assume that a register write and a cpu_tick never fall in the same clock. Under that assumption, a counter reload always uses a reload value that was settled before the advance. The stimulus keeps cpu_tick low in every cycle in which it asserts wr_en. It also spaces tick bursts with idle cycles, so that holding the count while ticks are absent is exercised alongside counting. The prescaler bound assertion assumes that the constants 341 and 3 are left at their defaults.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

    localparam int CNT_W      = 8;
    localparam int PRE_W      = 10;
    localparam int PRE_RELOAD = 341;
    localparam int PRE_STEP   = 3;

    typedef enum logic [1:0] {
        SEL_RLD_LO = 2'd0,
        SEL_RLD_HI = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_ACK    = 2'd3
    } sel_e;

    typedef struct packed {
        logic cycle_pace;
        logic enable;
        logic en_after_ack;
    } ctrl_t;

    function automatic logic [7:0] merge_nibble(input logic [7:0] cur,
                                                input logic [3:0] nib,
                                                input logic       upper);
        return upper ? {nib, cur[3:0]} : {cur[7:4], nib};
    endfunction

endpackage

// File: rtl/irqtmr_regs.sv
module irqtmr_regs
    import irqtmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [7:0]   wr_data,
    output logic [W-1:0] reload_o,
    output ctrl_t        ctrl_o,
    output logic         load_o,
    output logic         clr_irq_o
);
    logic [7:0] rld_q;
    ctrl_t      ctrl_q;
    sel_e       sel;
    logic       unused_hi;

    assign sel       = sel_e'(wr_sel);
    assign unused_hi = ^wr_data[7:4];

    always_ff @(posedge clk) begin
        if (rst) begin
            rld_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_RLD_LO: rld_q <= merge_nibble(rld_q, wr_data[3:0], 1'b0);
                SEL_RLD_HI: rld_q <= merge_nibble(rld_q, wr_data[3:0], 1'b1);
                SEL_CTRL:   ctrl_q <= ctrl_t'(wr_data[2:0]);
                SEL_ACK:    ctrl_q.enable <= ctrl_q.en_after_ack;
                default:    ;
            endcase
        end
    end

    assign reload_o  = W'(rld_q);
    assign ctrl_o    = ctrl_q;
    assign load_o    = wr_en && (sel == SEL_CTRL) && wr_data[1];
    assign clr_irq_o = wr_en && (sel == SEL_CTRL || sel == SEL_ACK);

    p_ack_copy_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=> (ctrl_q.enable == $past(ctrl_q.en_after_ack)));

    p_reload_keep_r1: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rld_q));

endmodule

// File: rtl/irqtmr_prescaler.sv
module irqtmr_prescaler
    import irqtmr_pkg::*;
#(
    parameter int PW     = PRE_W,
    parameter int RELOAD = PRE_RELOAD,
    parameter int STEP   = PRE_STEP
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic active,
    output logic step_o
);
    localparam logic signed [PW-1:0] RLD_S  = PW'(RELOAD);
    localparam logic signed [PW-1:0] STEP_S = PW'(STEP);

    logic signed [PW-1:0] pre_q;
    logic signed [PW-1:0] dec;

    assign dec    = pre_q - STEP_S;
    assign step_o = active && (dec <= 0);

    always_ff @(posedge clk) begin
        if (rst)           pre_q <= '0;
        else if (load)     pre_q <= RLD_S;
        else if (step_o)   pre_q <= dec + RLD_S;
        else if (active)   pre_q <= dec;
    end

    p_pre_bounds_r5: assert property (@(posedge clk) disable iff (rst)
        (pre_q <= RLD_S) && (pre_q >= -STEP_S));

    p_pre_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!active && !load) |=> $stable(pre_q));

endmodule

// File: rtl/irqtmr_counter.sv
module irqtmr_counter
    import irqtmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] reload,
    output logic         ovf_o
);
    logic [W-1:0] cnt_q;

    assign ovf_o = adv && (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (load)  cnt_q <= reload;
        else if (ovf_o) cnt_q <= reload;
        else if (adv)   cnt_q <= cnt_q + 1'b1;
    end

    p_wrap_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !load) |=> (cnt_q == $past(reload)));

    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/irqtmr_top.sv
module irqtmr_top
    import irqtmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       cpu_tick,
    input  logic       run_en,
    output logic       irq
);
    logic [W-1:0] reload;
    ctrl_t        ctrl;
    logic         load, clr_irq, running, pre_step, adv, ovf;
    logic         irq_q;

    irqtmr_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .reload_o(reload), .ctrl_o(ctrl), .load_o(load), .clr_irq_o(clr_irq)
    );

    assign running = run_en && ctrl.enable && cpu_tick && !load;

    irqtmr_prescaler u_pre (
        .clk(clk), .rst(rst), .load(load),
        .active(running && !ctrl.cycle_pace), .step_o(pre_step)
    );

    assign adv = running && (ctrl.cycle_pace || pre_step);

    irqtmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .adv(adv), .reload(reload), .ovf_o(ovf)
    );

    always_ff @(posedge clk) begin
        if (rst)          irq_q <= 1'b0;
        else if (ovf)     irq_q <= 1'b1;
        else if (clr_irq) irq_q <= 1'b0;
    end

    assign irq = irq_q;

    p_irq_held_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clr_irq) |=> irq_q);

    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !irq_q) |=> !irq_q);

    p_reset_clear_r8: assert property (@(posedge clk)
        $past(rst) |-> !irq_q);

    p_clear_on_write_r2: assert property (@(posedge clk) disable iff (rst)
        (clr_irq && !cpu_tick) |=> !irq_q);

endmodule

// File: tb/irqtmr_top_tb.sv
module irqtmr_top_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       cpu_tick = 1'b0;
    logic       run_en = 1'b1;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irqtmr_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cpu_tick(cpu_tick), .run_en(run_en), .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_sel = s; wr_data = d; wr_en = 1'b1; cpu_tick = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cpu_tick = 1'b1;
        end
        @(negedge clk);
        cpu_tick = 1'b0;
    endtask

    task automatic set_reload(input logic [7:0] v);
        wr(2'd0, {4'h9, v[3:0]});
        wr(2'd1, {4'h6, v[7:4]});
    endtask

    // Ticks from a fresh load (prescaler at 341) until the counter wraps.
    function automatic int scan_ticks(input int start);
        int pre = 341;
        int cnt = start;
        int t = 0;
        while (1) begin
            t++;
            pre -= 3;
            if (pre <= 0) begin
                pre += 341;
                if (cnt == 255) return t;
                cnt++;
            end
        end
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: irq=%0b expected completion", irq);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset clears everything; ticks do nothing while disabled
        chk("R8 reset irq", irq, 1'b0);
        ticks(300);
        chk("R8 disabled after reset", irq, 1'b0);

        // R1 R4 R6 R2: exhaustive reload sweep in cycle pacing
        for (int l = 0; l < 256; l++) begin
            set_reload(8'(l));
            wr(2'd2, 8'h06);
            chk("R2 ctrl write clears irq", irq, 1'b0);
            if (256 - l > 1) begin
                ticks(256 - l - 1);
                chk("R4 no wrap before 256-L ticks", irq, 1'b0);
            end
            ticks(1);
            chk("R6 wrap raises irq R1", irq, 1'b1);
        end

        // R6: irq stays high; reload used for the second lap; R9 idle hold
        set_reload(8'hF0);
        wr(2'd2, 8'h06);
        ticks(8);
        repeat (20) @(negedge clk);
        ticks(7);
        chk("R9 idle cycles do not count", irq, 1'b0);
        ticks(1);
        chk("R6 irq after 16", irq, 1'b1);
        ticks(40);
        chk("R6 irq held", irq, 1'b1);

        // R3: ack with enable-after-ack set keeps counting from the reload value
        set_reload(8'hE0);
        wr(2'd2, 8'h07);
        ticks(32);
        chk("R6 wrap at 32", irq, 1'b1);
        wr(2'd3, 8'h00);
        chk("R3 ack clears irq", irq, 1'b0);
        ticks(31);
        chk("R3 still counting, no early wrap", irq, 1'b0);
        ticks(1);
        chk("R3 second lap wraps", irq, 1'b1);

        // R3: ack with enable-after-ack clear disables
        wr(2'd2, 8'h06);
        ticks(32);
        chk("R6 wrap at 32 again", irq, 1'b1);
        wr(2'd3, 8'h00);
        chk("R3 ack clears irq", irq, 1'b0);
        ticks(400);
        chk("R3 ack disabled timer", irq, 1'b0);

        // R2: control without enable does not count
        wr(2'd2, 8'h04);
        ticks(400);
        chk("R2 enable clear no count", irq, 1'b0);

        // R5: scanline pacing
        for (int k = 1; k <= 5; k++) begin
            int n;
            n = scan_ticks(256 - k);
            set_reload(8'(256 - k));
            wr(2'd2, 8'h02);
            ticks(n - 1);
            chk("R5 no wrap before prescaled period", irq, 1'b0);
            ticks(1);
            chk("R5 wrap at prescaled period", irq, 1'b1);
        end
        chk("R5 period 3 steps is 341", (scan_ticks(253) == 341), 1'b1);

        // R7: run_en low freezes counter and prescaler
        set_reload(8'hFE);
        wr(2'd2, 8'h02);
        ticks(100);
        run_en = 1'b0;
        ticks(500);
        chk("R7 frozen no irq", irq, 1'b0);
        run_en = 1'b1;
        ticks(127);
        chk("R7 resumes where it stopped", irq, 1'b0);
        ticks(1);
        chk("R7 wrap after resume", irq, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule